// File: doc/BRIEF.md
# Display Link Lane Count Calculator

This block works out how many serial lanes a display link must use to carry a given pixel stream. A request carries three values: the pixel clock in kHz, a 3-bit colour-depth code and the link frequency in MHz. The block decodes the colour depth into bits per pixel and derives the usable byte rate of one lane. Each byte costs ten line bits, so the byte rate is the frequency times 100. The block then raises the needed bit rate by a 5% spread-spectrum allowance and divides it, rounding up, by eight times the lane byte rate.

Requests enter through a valid/ready pair. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. From that edge until its result appears, `in_ready` stays low, and `in_valid` is ignored for as long as `in_ready` is low. The result is presented for exactly one cycle with `out_valid` high. There is no back-pressure on the result side: a consumer must capture it in that cycle. The rounding-up division uses a bit-serial restoring divider, so a legal request takes a fixed number of cycles. An illegal request skips the divide and answers at once.

Top module: `lane_calc`

## Requirements
- R1: Colour-depth code 0 gives 24 bits per pixel, code 1 gives 30, code 2 gives 18 and code 3 gives 36 on `bpp`.
- R2: Codes 4 to 7 give `bpp` = 0, `err` = 1 and `lanes` = 0, with `out_valid` one cycle after the accepting edge.
- R3: `lane_bw` equals `freq_mhz` × 100 for every accepted request.
- R4: For a legal request, `lanes` equals ceil(floor(pclk_khz × bpp × 21 / 20) / (8 × lane_bw)); a zero pixel clock gives 0 lanes.
- R5: `err` is 1 when the lane count computed for a legal request exceeds 4, and 0 when it is 4 or less.
- R6: `freq_mhz` = 0 gives `err` = 1, `lanes` = 0 and `lane_bw` = 0, with `bpp` still decoded and the result one cycle after acceptance, without running a divide.
- R7: For a legal request with nonzero frequency, `out_valid` rises QW+2 clock edges after the accepting edge (34 at default), and every `out_valid` lasts exactly one cycle.
- R8: `in_ready` is low from the accepting edge until the result appears and is high again in the result cycle; `in_valid` pulses while `in_ready` is low start no request and produce no result.
- R9: During and right after reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| pclk_khz | input | PCLK_W (20) | Pixel clock in kHz |
| depth_code | input | 3 | Colour-depth code |
| freq_mhz | input | FREQ_W (12) | Link frequency in MHz |
| out_valid | output | 1 | One-cycle result strobe |
| bpp | output | 6 | Bits per pixel of the last request |
| lane_bw | output | FREQ_W+7 (19) | Per-lane byte bandwidth |
| lanes | output | QW (32) | Lane count |
| err | output | 1 | Illegal depth, zero frequency or more than four lanes |

## Verification
An illegal depth code or a zero frequency must produce its result one edge after the accepting edge; a legal request must produce it QW+2 edges after, because the divider loads one edge after acceptance, spends QW edges shifting and hands over its quotient on one more edge. The bench counts clock edges, notes the count at the accepting edge for each request it queues, and has the monitor compare the edge count when `out_valid` appears against the latency the requirements give. Values are sampled on falling edges, half a cycle after the register that drives them changes. A result that appears with nothing queued counts as a failure, and so does a queue left full at the end. This catches both late strobes and requests wrongly taken while busy.

// File: rtl/lane_calc_pkg.sv
package lane_calc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } calc_state_t;

  localparam int BPP_W   = 6;
  localparam int DEPTH_W = 3;
endpackage

// File: rtl/lane_calc_depth.sv
module lane_calc_depth
  import lane_calc_pkg::*;
(
  input  logic [DEPTH_W-1:0] code,
  output logic [BPP_W-1:0]   bpp,
  output logic               legal
);
  always_comb begin
    legal = 1'b1;
    case (code)
      3'd0:    bpp = 6'd24;
      3'd1:    bpp = 6'd30;
      3'd2:    bpp = 6'd18;
      3'd3:    bpp = 6'd36;
      default: begin
        bpp   = '0;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lane_calc_prep.sv
module lane_calc_prep
  import lane_calc_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int FREQ_W = 12,
  parameter int QW     = 32
) (
  input  logic [PCLK_W-1:0]  pclk_khz,
  input  logic [FREQ_W-1:0]  freq_mhz,
  input  logic [BPP_W-1:0]   bpp,
  output logic [FREQ_W+6:0]  lane_bw,
  output logic [QW-1:0]      dividend,
  output logic [QW-1:0]      divisor
);
  localparam int BW_W = FREQ_W + 7;

  logic [QW-1:0] prod;
  logic [QW-1:0] need;
  logic [QW-1:0] bw_ext;

  always_comb begin
    lane_bw  = BW_W'(freq_mhz) * BW_W'(100);
    bw_ext   = QW'(lane_bw);
    prod     = QW'(pclk_khz) * QW'(bpp) * QW'(21);
    need     = prod / QW'(20);
    divisor  = bw_ext << 3;
    dividend = need + divisor - QW'(1);
  end
endmodule

// File: rtl/lane_calc_div.sv
module lane_calc_div #(
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] dividend,
  input  logic [QW-1:0] divisor,
  output logic          done,
  output logic [QW-1:0] quotient
);
  localparam int CW = $clog2(QW + 1);

  logic [QW-1:0] rem_q, quo_q, div_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [QW:0]   rem_sh;
  logic [QW+1:0] diff;

  always_comb begin
    rem_sh = {rem_q, quo_q[QW-1]};
    diff   = {1'b0, rem_sh} - {2'b00, div_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        quo_q  <= dividend;
        div_q  <= divisor;
        cnt_q  <= CW'(QW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (!diff[QW+1]) begin
          rem_q <= diff[QW-1:0];
          quo_q <= {quo_q[QW-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh[QW-1:0];
          quo_q <= {quo_q[QW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R4
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < div_q));

  // R6
  start_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (divisor != '0));
endmodule

// File: rtl/lane_calc.sv
module lane_calc
  import lane_calc_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int FREQ_W = 12,
  parameter int QW     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PCLK_W-1:0]    pclk_khz,
  input  logic [DEPTH_W-1:0]   depth_code,
  input  logic [FREQ_W-1:0]    freq_mhz,
  output logic                 out_valid,
  output logic [BPP_W-1:0]     bpp,
  output logic [FREQ_W+6:0]    lane_bw,
  output logic [QW-1:0]        lanes,
  output logic                 err
);
  localparam int BW_W = FREQ_W + 7;

  calc_state_t     state_q;
  logic [BPP_W-1:0] bpp_c;
  logic             legal_c;
  logic [BW_W-1:0]  bw_c;
  logic [QW-1:0]    dividend_c, divisor_c, dividend_q, divisor_q, quo;
  logic             div_start_q, div_done;
  logic             take;

  lane_calc_depth u_depth (
    .code  (depth_code),
    .bpp   (bpp_c),
    .legal (legal_c)
  );

  lane_calc_prep #(.PCLK_W(PCLK_W), .FREQ_W(FREQ_W), .QW(QW)) u_prep (
    .pclk_khz (pclk_khz),
    .freq_mhz (freq_mhz),
    .bpp      (bpp_c),
    .lane_bw  (bw_c),
    .dividend (dividend_c),
    .divisor  (divisor_c)
  );

  lane_calc_div #(.QW(QW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start_q),
    .dividend (dividend_q),
    .divisor  (divisor_q),
    .done     (div_done),
    .quotient (quo)
  );

  assign in_ready = (state_q == ST_IDLE);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      div_start_q <= 1'b0;
      dividend_q  <= '0;
      divisor_q   <= '0;
      out_valid   <= 1'b0;
      bpp         <= '0;
      lane_bw     <= '0;
      lanes       <= '0;
      err         <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      div_start_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (take) begin
          bpp        <= bpp_c;
          lane_bw    <= bw_c;
          dividend_q <= dividend_c;
          divisor_q  <= divisor_c;
          if (!legal_c || freq_mhz == '0) begin
            state_q <= ST_FIN;
          end else begin
            state_q     <= ST_DIV;
            div_start_q <= 1'b1;
          end
        end
        ST_FIN: begin
          out_valid <= 1'b1;
          lanes     <= '0;
          err       <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_DIV: if (div_done) begin
          out_valid <= 1'b1;
          lanes     <= quo;
          err       <= (quo > QW'(4));
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R5
  lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> (lanes <= QW'(4)));

  // R2
  zero_bpp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bpp == '0) |-> err);
endmodule

// File: tb/lane_calc_tb.sv
module lane_calc_tb;
  localparam int PCLK_W = 20;
  localparam int FREQ_W = 12;
  localparam int QW     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [PCLK_W-1:0] pclk_khz = '0;
  logic [2:0]        depth_code = '0;
  logic [FREQ_W-1:0] freq_mhz = '0;
  logic              out_valid;
  logic [5:0]        bpp;
  logic [FREQ_W+6:0] lane_bw;
  logic [QW-1:0]     lanes;
  logic              err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    longint bpp;
    longint bw;
    longint lanes;
    bit     err;
    int     lat;
    int     acc;
    string  tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_calc #(.PCLK_W(PCLK_W), .FREQ_W(FREQ_W), .QW(QW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pclk_khz(pclk_khz), .depth_code(depth_code), .freq_mhz(freq_mhz),
    .out_valid(out_valid), .bpp(bpp), .lane_bw(lane_bw), .lanes(lanes), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input longint pc, input int code, input longint fr, input string tag);
    exp_t e;
    bit legal = 1;
    case (code)
      0: e.bpp = 24;
      1: e.bpp = 30;
      2: e.bpp = 18;
      3: e.bpp = 36;
      default: begin e.bpp = 0; legal = 0; end
    endcase
    e.bw = fr * 100;
    e.tag = tag;
    if (!legal || fr == 0) begin
      e.lanes = 0; e.err = 1; e.lat = 1;
    end else begin
      longint need = (pc * e.bpp * 21) / 20;
      longint d = 8 * e.bw;
      e.lanes = (need + d - 1) / d;
      e.err = (e.lanes > 4);
      e.lat = QW + 2;
    end
    return e;
  endfunction

  task automatic send(input int pc, input int code, input int fr, input string tag);
    exp_t e;
    e = model(pc, code, fr, tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    pclk_khz = PCLK_W'(pc);
    depth_code = 3'(code);
    freq_mhz = FREQ_W'(fr);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e.acc = cyc;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R8 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(bpp == e.bpp, {e.tag, " R1 bpp"}, bpp, e.bpp);
        chk(lane_bw == e.bw, {e.tag, " R3 lane_bw"}, lane_bw, e.bw);
        chk(lanes == e.lanes, {e.tag, " R4 lanes"}, lanes, e.lanes);
        chk(err == e.err, {e.tag, " R5 err"}, err, e.err);
        chk((cyc - e.acc) == e.lat, {e.tag, " R7 latency"}, cyc - e.acc, e.lat);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);

    send(148500, 0, 2700, "R1 code0");     drain();
    send(65000, 2, 1620, "R4 code2");      drain();
    send(533250, 1, 2700, "R5 over four"); drain();
    send(160000, 3, 1890, "R5 exactly four"); drain();
    send(160001, 3, 1890, "R5 just over four"); drain();
    send(0, 0, 2700, "R4 zero pclk");      drain();
    send(148500, 5, 2700, "R2 code5");     drain();
    send(148500, 7, 2700, "R2 code7");     drain();
    send(148500, 0, 0, "R6 zero freq");    drain();
    send(5000, 1, 270, "R4 small link");   drain();

    // R8: requests offered while busy are ignored
    send(148500, 0, 2700, "R8 busy base");
    for (int i = 0; i < 6; i++) begin
      chk(in_ready == 1'b0, "R8 in_ready busy", in_ready, 0);
      pclk_khz = 20'd999;
      depth_code = 3'd6;
      freq_mhz = 12'd0;
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    repeat (QW + 6) @(negedge clk);
    chk(q.size() == 0, "R8 queue empty", q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule